// File: doc/BRIEF.md
# SPD Store with Per-Block Write Protection

This block holds the 512-byte serial-presence-detect image of a memory module and controls who may change it. The array is split into four 128-byte blocks, and each block has its own protection flag that software can set or clear. A serial slave front end talks to the store through a single-byte access port: one request strobe, a write enable, a 9-bit byte address and write data. The store answers one cycle later with an acknowledge and, for reads, the data byte.

An accepted write to a writable location starts an internal programming period that lasts a fixed number of clock cycles. During that period every new access is refused: no acknowledge comes back. A write aimed at a protected block is acknowledged but thrown away, and it starts no programming period. The 64-byte range 100h–13Fh is reserved. It always reads as zero and it drops writes. At reset the lower three blocks are protected and the top block is writable.

Top module: `spd_wp_store`

## Requirements
- R1: After reset, the protection status is 0111 (bit n is the flag of block n, 1 = protected), ack_o is low, busy_o is low and the array reads as 00h.
- R2: A request that is accepted gives ack_o high for exactly one cycle, in the cycle after the request. Without a request, ack_o stays low.
- R3: The block of an address is addr_i[8:7]. A write to an unprotected block that is outside the reserved range is stored, and a later read of that address returns the byte.
- R4: A write to a protected block is acknowledged, leaves the array unchanged and does not raise busy_o.
- R5: Reads of addresses 100h–13Fh return 00h. Writes there are acknowledged, discarded and do not raise busy_o, even when block 2 is unprotected.
- R6: An accepted write to a writable location holds busy_o high for exactly WR_CYCLES cycles, starting in the cycle after the request.
- R7: While busy_o is high, a request gets no acknowledge and has no effect on the array.
- R8: A pulse on prot_set_i sets the flag of block prot_sel_i, and a pulse on prot_clr_i clears it. When both are high in the same cycle, the set wins. The new flag shows on prot_o in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Single-cycle access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 9 | Byte address |
| wdata_i | input | 8 | Write data |
| ack_o | output | 1 | Access accepted, one cycle after req_i |
| rdata_o | output | 8 | Read data, valid with ack_o on a read |
| busy_o | output | 1 | Programming period in progress |
| prot_set_i | input | 1 | Set protection of the selected block |
| prot_clr_i | input | 1 | Clear protection of the selected block |
| prot_sel_i | input | 2 | Block chosen by the protection commands |
| prot_o | output | 4 | Protection flag of each block |

## Verification
The assertions assume that req_i is a single-cycle strobe and that addr_i, we_i and wdata_i are valid in the cycle req_i is high. They also assume the protection commands are pulses that may arrive at any time, including while a write is being programmed. The bench drives every request for exactly one cycle on the falling clock edge and drops it afterwards. Between table vectors it waits until busy_o falls. Only the directed busy test issues requests on purpose while the store is programming.

// File: rtl/spd_wp_pkg.sv
package spd_wp_pkg;
  localparam int unsigned NUM_BLK   = 4;
  localparam int unsigned BLK_BYTES = 128;
  localparam int unsigned MEM_BYTES = NUM_BLK * BLK_BYTES;
  localparam int unsigned ADDR_W    = $clog2(MEM_BYTES);
  localparam int unsigned BLK_W     = $clog2(NUM_BLK);
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned RSV_LO    = 'h100;
  localparam int unsigned RSV_HI    = 'h13F;
  localparam logic [NUM_BLK-1:0] PROT_RST = 4'b0111;
endpackage

// File: rtl/spd_wp_decode.sv
module spd_wp_decode #(
  parameter int unsigned ADDR_W = spd_wp_pkg::ADDR_W,
  parameter int unsigned BLK_W  = spd_wp_pkg::BLK_W,
  parameter int unsigned RSV_LO = spd_wp_pkg::RSV_LO,
  parameter int unsigned RSV_HI = spd_wp_pkg::RSV_HI
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BLK_W-1:0]  blk_o,
  output logic              rsv_o
);
  localparam logic [ADDR_W-1:0] LO = ADDR_W'(RSV_LO);
  localparam logic [ADDR_W-1:0] HI = ADDR_W'(RSV_HI);

  assign blk_o = addr_i[ADDR_W-1 -: BLK_W];
  assign rsv_o = (addr_i >= LO) && (addr_i <= HI);
endmodule

// File: rtl/spd_wp_prot.sv
module spd_wp_prot #(
  parameter int unsigned NUM_BLK = spd_wp_pkg::NUM_BLK,
  parameter int unsigned BLK_W   = spd_wp_pkg::BLK_W,
  parameter logic [NUM_BLK-1:0] RST_VAL = spd_wp_pkg::PROT_RST
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_i,
  input  logic               clr_i,
  input  logic [BLK_W-1:0]   sel_i,
  output logic [NUM_BLK-1:0] prot_o
);
  logic [NUM_BLK-1:0] prot_q;

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prot_q[b] <= RST_VAL[b];
      end else if (sel_i == BLK_W'(b)) begin
        // set has priority over clear
        if (set_i)      prot_q[b] <= 1'b1;
        else if (clr_i) prot_q[b] <= 1'b0;
      end
    end
  end

  assign prot_o = prot_q;

  // R8
  prot_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> prot_o[$past(sel_i)]);
  // R8
  prot_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !prot_o[$past(sel_i)]);
  // R8
  prot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(prot_o));
endmodule

// File: rtl/spd_wp_timer.sv
module spd_wp_timer #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= LOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);

  // R6
  wr_cnt_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !start_i) |=> (cnt_q == $past(cnt_q) - CW'(1)));
  // R6
  wr_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cnt_q == LOAD));
  // R6
  wr_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LOAD);
endmodule

// File: rtl/spd_wp_store.sv
module spd_wp_store
  import spd_wp_pkg::*;
#(
  parameter int unsigned WR_CYCLES = 1000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic               ack_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               busy_o,
  input  logic               prot_set_i,
  input  logic               prot_clr_i,
  input  logic [BLK_W-1:0]   prot_sel_i,
  output logic [NUM_BLK-1:0] prot_o
);
  logic [BLK_W-1:0]  blk;
  logic              rsv;
  logic              accept;
  logic              wr_ok;
  logic              ack_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] mem_q [MEM_BYTES];

  spd_wp_decode u_dec (
    .addr_i (addr_i),
    .blk_o  (blk),
    .rsv_o  (rsv)
  );

  spd_wp_prot u_prot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (prot_set_i),
    .clr_i  (prot_clr_i),
    .sel_i  (prot_sel_i),
    .prot_o (prot_o)
  );

  spd_wp_timer #(.CYCLES(WR_CYCLES)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (wr_ok),
    .busy_o  (busy_o)
  );

  assign accept = req_i && !busy_o;
  // protected or reserved writes are acked but dropped
  assign wr_ok  = accept && we_i && !prot_o[blk] && !rsv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(MEM_BYTES); i++) mem_q[i] <= '0;
    end else if (wr_ok) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q <= accept;
      if (accept && !we_i) rdata_q <= rsv ? '0 : mem_q[addr_i];
    end
  end

  assign ack_o   = ack_q;
  assign rdata_o = rdata_q;

  // R7
  busy_nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && busy_o) |=> !ack_o);
  // R2
  idle_nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ack_o);
  // R4
  prot_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !busy_o && prot_o[addr_i[ADDR_W-1 -: BLK_W]]) |=> (ack_o && !busy_o));
  // R5
  rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !busy_o && addr_i >= ADDR_W'(RSV_LO) && addr_i <= ADDR_W'(RSV_HI))
    |=> (ack_o && rdata_o == '0));
  // R6
  wr_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !busy_o && !prot_o[addr_i[ADDR_W-1 -: BLK_W]]
     && (addr_i < ADDR_W'(RSV_LO) || addr_i > ADDR_W'(RSV_HI))) |=> (ack_o && busy_o));
endmodule

// File: tb/spd_wp_store_tb.sv
`timescale 1ns/1ps
module spd_wp_store_tb_top;
  localparam int WR = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0;
  logic [8:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       ack, busy;
  logic [7:0] rdata;
  logic       pset = 1'b0, pclr = 1'b0;
  logic [1:0] psel = '0;
  logic [3:0] prot;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  spd_wp_store #(.WR_CYCLES(WR)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata), .busy_o(busy),
    .prot_set_i(pset), .prot_clr_i(pclr), .prot_sel_i(psel), .prot_o(prot)
  );

  // {req tag, we, addr, wdata, expected rdata, expected busy}
  localparam int NV = 10;
  localparam logic [30:0] VEC [NV] = '{
    {4'd3, 1'b1, 9'h180, 8'hA5, 8'h00, 1'b1},
    {4'd3, 1'b0, 9'h180, 8'h00, 8'hA5, 1'b0},
    {4'd3, 1'b1, 9'h1FF, 8'h3C, 8'h00, 1'b1},
    {4'd3, 1'b0, 9'h1FF, 8'h00, 8'h3C, 1'b0},
    {4'd4, 1'b1, 9'h000, 8'h11, 8'h00, 1'b0},
    {4'd4, 1'b0, 9'h000, 8'h00, 8'h00, 1'b0},
    {4'd4, 1'b1, 9'h0FF, 8'h22, 8'h00, 1'b0},
    {4'd4, 1'b0, 9'h0FF, 8'h00, 8'h00, 1'b0},
    {4'd5, 1'b0, 9'h100, 8'h00, 8'h00, 1'b0},
    {4'd5, 1'b0, 9'h13F, 8'h00, 8'h00, 1'b0}
  };

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // one-cycle request; returns sampled on the falling edge after the edge
  task automatic access(input bit w, input logic [8:0] a, input logic [7:0] d);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic prot_cmd(input bit s, input bit c, input logic [1:0] b);
    pset = s; pclr = c; psel = b;
    @(negedge clk);
    pset = 1'b0; pclr = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(prot == 4'b0111, "R1", "prot_o", prot, 4'b0111);
    check(!ack && !busy, "R1", "ack/busy", {ack, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!ack, "R2", "ack without req", ack, 0);

    for (int i = 0; i < NV; i++) begin
      logic [30:0] v;
      v = VEC[i];
      access(v[26], v[25:17], v[16:9]);
      check(ack == 1'b1, $sformatf("R%0d", v[30:27]), "ack", ack, 1);
      check(busy == v[0], $sformatf("R%0d", v[30:27]), "busy", busy, v[0]);
      if (!v[26])
        check(rdata == v[8:1], $sformatf("R%0d", v[30:27]), "rdata", rdata, v[8:1]);
      wait_idle();
    end

    // R2 ack lasts one cycle
    access(1'b0, 9'h180, 8'h00);
    @(negedge clk);
    check(!ack, "R2", "ack width", ack, 0);

    // R6 busy window length
    access(1'b1, 9'h1A0, 8'h77);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    check(n == WR, "R6", "busy cycles", n, WR);

    // R7 access refused while busy, write has no effect
    access(1'b1, 9'h1A1, 8'h55);
    access(1'b0, 9'h1A0, 8'h00);
    check(!ack, "R7", "ack while busy (read)", ack, 0);
    access(1'b1, 9'h1A2, 8'h99);
    check(!ack, "R7", "ack while busy (write)", ack, 0);
    wait_idle();
    access(1'b0, 9'h1A2, 8'h00);
    check(ack && rdata == 8'h00, "R7", "dropped write", rdata, 0);
    access(1'b0, 9'h1A1, 8'h00);
    check(rdata == 8'h55, "R3", "readback", rdata, 8'h55);

    // R8 clear block 0 then write it
    prot_cmd(1'b0, 1'b1, 2'd0);
    check(prot == 4'b0110, "R8", "clear", prot, 4'b0110);
    access(1'b1, 9'h005, 8'hC3);
    check(busy, "R3", "busy after write", busy, 1);
    wait_idle();
    access(1'b0, 9'h005, 8'h00);
    check(rdata == 8'hC3, "R3", "block0 readback", rdata, 8'hC3);

    // R8 set block 3; R4 write dropped
    prot_cmd(1'b1, 1'b0, 2'd3);
    check(prot == 4'b1110, "R8", "set", prot, 4'b1110);
    access(1'b1, 9'h180, 8'hEE);
    check(ack && !busy, "R4", "ack/busy", {ack, busy}, 2);
    access(1'b0, 9'h180, 8'h00);
    check(rdata == 8'hA5, "R4", "unchanged", rdata, 8'hA5);

    // R8 set wins when both strobes are high
    prot_cmd(1'b0, 1'b1, 2'd3);
    prot_cmd(1'b1, 1'b1, 2'd3);
    check(prot == 4'b1110, "R8", "set priority", prot, 4'b1110);

    // R5 reserved range with block 2 unprotected
    prot_cmd(1'b0, 1'b1, 2'd2);
    check(prot == 4'b1010, "R8", "clear block2", prot, 4'b1010);
    access(1'b1, 9'h120, 8'h5A);
    check(ack && !busy, "R5", "reserved write", {ack, busy}, 2);
    access(1'b0, 9'h120, 8'h00);
    check(rdata == 8'h00, "R5", "reserved read", rdata, 0);
    access(1'b1, 9'h150, 8'h6B);
    check(busy, "R5", "above reserved busy", busy, 1);
    wait_idle();
    access(1'b0, 9'h150, 8'h00);
    check(rdata == 8'h6B, "R5", "above reserved readback", rdata, 8'h6B);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule